// File: doc/BRIEF.md
# Pulse Accumulator and Timer Clock Selector

The block counts rising edges of an external pulse input in a 16-bit accumulator. The pulse input is brought into the system clock domain by a two-flop synchroniser, and an edge detector produces a one-cycle count event. Each counted edge sets an input-edge flag. When the count wraps from all ones back to zero, an overflow flag is set. Each flag drives an interrupt line through its own enable bit.

The block also chooses the clock enable for a separate timer counter. The choices are a prescaler tick supplied from outside, the counted-edge tick itself, a tick when the low byte of the accumulator carries out (one per 256 counted edges), or a tick when the whole count wraps (one per 65,536 counted edges). While the accumulator is disabled, the prescaler tick is passed through whatever the select field holds. All clocks here are single-cycle enable strobes in the system clock domain.

Software uses a plain register bus with a write strobe and a combinational read port. There is no stream interface, so no valid/ready handshake applies. Control and status pins are plain levels.

Top module: `pacc_clksel`

## Requirements
- R1: While enable bit 0 of the control register (address 0) is 1, each rising edge of pulse_in adds one to the count, which is read at address 2. An edge first sampled high at clock edge k shows in the count after edge k+2. While enable is 0, or when no edge is seen, the count holds.
- R2: A write to address 2 loads the count from reg_wdata. If a count write and a counted edge fall in the same cycle, the write wins, and that edge is neither counted nor flagged.
- R3: A counted edge that takes the count from 0xFFFF to 0x0000 sets the overflow flag. A count write never sets it.
- R4: Every counted edge sets the input-edge flag.
- R5: The flag register (address 1) holds the overflow flag in bit 1 and the input-edge flag in bit 0. Bits 15 to 2 read as 0. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged. The register can be read or written in any cycle.
- R6: When a hardware set and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R7: irq_ovf equals the overflow flag ANDed with control bit 1. irq_edge equals the input-edge flag ANDed with control bit 2.
- R8: Control bits 4:3 select tmr_clk while enable is 1. 00 selects presc_clk. 01 selects the counted-edge tick. 10 selects the tick of a counted edge seen while the low byte is 0xFF. 11 selects the tick of a counted edge seen while the count is 0xFFFF. Each tick is high for one cycle, in the cycle before the count changes.
- R9: While enable is 0, tmr_clk equals presc_clk for every value of the select bits.
- R10: A new select value reaches tmr_clk in the cycle right after the control write edge, with no added synchronising delay.
- R11: Reset clears the count, both flags, and all control bits (enable, both interrupt enables, select). Control reads back at address 0 in bits 4:0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 flags, 2 count) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for reg_addr |
| pulse_in | input | 1 | External pulse input, asynchronous |
| presc_clk | input | 1 | Prescaler clock-enable tick |
| tmr_clk | output | 1 | Selected timer counter clock enable |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Input-edge interrupt request |

## Verification
A pulse edge takes two clock edges to pass through the synchroniser. The tick appears on tmr_clk during the third cycle after the pulse is first sampled high, and the count, the flags and the interrupt lines change at the edge that closes that cycle. Register writes show on reg_rdata and the interrupt lines one edge after the write. A select change shows on tmr_clk within the same following cycle. The bench model keeps its own three-sample history of pulse_in and steps once per rising clock. Inputs are driven 1 ns after the edge and every output is compared at the falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int FLG_OVF = 1;
  localparam int FLG_EDGE = 0;
  localparam int NUM_FLG = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_FLAG = 2'd1,
    A_CNT  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    SEL_PRESC    = 2'b00,
    SEL_PULSE    = 2'b01,
    SEL_DIV_LO   = 2'b10,
    SEL_DIV_FULL = 2'b11
  } clk_sel_e;

  // bit 4:3 select, bit 2 edge irq enable, bit 1 overflow irq enable, bit 0 accumulator enable
  typedef struct packed {
    clk_sel_e sel;
    logic     edge_ie;
    logic     ovf_ie;
    logic     acc_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pacc_edge_sync.sv
module pacc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_in,
  output logic rise
);
  localparam int SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], pulse_in};
  end

  // newest synchronised sample against the one before it
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int CNT_W = 16,
  parameter int LO_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             lo_carry,
  output logic             wrap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (step) cnt <= cnt + 1'b1;
  end

  assign lo_carry = step & (&cnt[LO_W-1:0]);
  assign wrap     = step & (&cnt);
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pacc_clkmux.sv
module pacc_clkmux
  import pacc_pkg::*;
(
  input  logic     acc_en,
  input  clk_sel_e sel,
  input  logic     presc_clk,
  input  logic     pulse_tick,
  input  logic     lo_tick,
  input  logic     full_tick,
  output logic     tmr_clk
);
  always_comb begin
    if (!acc_en) tmr_clk = presc_clk;
    else begin
      unique case (sel)
        SEL_PRESC:    tmr_clk = presc_clk;
        SEL_PULSE:    tmr_clk = pulse_tick;
        SEL_DIV_LO:   tmr_clk = lo_tick;
        SEL_DIV_FULL: tmr_clk = full_tick;
        default:      tmr_clk = presc_clk;
      endcase
    end
  end
endmodule

// File: rtl/pacc_clksel.sv
module pacc_clksel
  import pacc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LO_W        = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 pulse_in,
  input  logic                 presc_clk,
  output logic                 tmr_clk,
  output logic                 irq_ovf,
  output logic                 irq_edge
);
  ctrl_t              ctrl_q;
  logic               acc_en;
  logic               pulse_rise;
  logic               cnt_ld;
  logic               flag_wr;
  logic               step;
  logic               lo_carry;
  logic               wrap;
  logic [DATA_W-1:0]  cnt_q;
  logic [NUM_FLG-1:0] flag_q;
  logic [NUM_FLG-1:0] flag_set;
  logic [NUM_FLG-1:0] flag_clr;

  assign acc_en  = ctrl_q.acc_en;
  assign cnt_ld  = reg_wr && (reg_addr == A_CNT);
  assign flag_wr = reg_wr && (reg_addr == A_FLAG);
  assign step    = pulse_rise & acc_en & ~cnt_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (reg_wr && (reg_addr == A_CTRL)) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  pacc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .rise(pulse_rise)
  );

  pacc_counter #(.CNT_W(DATA_W), .LO_W(LO_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .ld(cnt_ld), .ld_val(reg_wdata),
    .cnt(cnt_q), .lo_carry(lo_carry), .wrap(wrap)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_OVF]  = wrap;
    flag_set[FLG_EDGE] = step;
    flag_clr           = flag_wr ? reg_wdata[NUM_FLG-1:0] : '0;
  end

  pacc_flags #(.N(NUM_FLG)) u_flg (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .q(flag_q)
  );

  pacc_clkmux u_mux (
    .acc_en(acc_en), .sel(ctrl_q.sel), .presc_clk(presc_clk),
    .pulse_tick(step), .lo_tick(lo_carry), .full_tick(wrap), .tmr_clk(tmr_clk)
  );

  assign irq_ovf  = flag_q[FLG_OVF] & ctrl_q.ovf_ie;
  assign irq_edge = flag_q[FLG_EDGE] & ctrl_q.edge_ie;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL:  reg_rdata[CTRL_W-1:0]  = ctrl_q;
      A_FLAG:  reg_rdata[NUM_FLG-1:0] = flag_q;
      A_CNT:   reg_rdata              = cnt_q;
      default: reg_rdata              = '0;
    endcase
  end
endmodule

// File: rtl/pacc_clksel_chk.sv
module pacc_clksel_chk
  import pacc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_ld,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              acc_en,
  input logic              pulse_rise,
  input logic [DATA_W-1:0] cnt_q,
  input logic [NUM_FLG-1:0] flag_q,
  input logic              irq_ovf,
  input logic              irq_edge,
  input logic              tmr_clk,
  input logic              presc_clk
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_ld && !(pulse_rise && acc_en)) |=> $stable(cnt_q));

  p_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_ld && pulse_rise && acc_en) |=> (cnt_q == $past(cnt_q) + 16'd1));

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> (cnt_q == $past(reg_wdata)));

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_ld && pulse_rise && acc_en && cnt_q == 16'hFFFF) |=> flag_q[FLG_OVF]);

  p_edge_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_ld && pulse_rise && acc_en) |=> flag_q[FLG_EDGE]);

  p_irq_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |-> flag_q[FLG_OVF]);

  p_irq_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge |-> flag_q[FLG_EDGE]);

  p_presc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (tmr_clk == presc_clk));
endmodule

bind pacc_clksel pacc_clksel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_ld(cnt_ld), .reg_wdata(reg_wdata),
  .acc_en(acc_en), .pulse_rise(pulse_rise), .cnt_q(cnt_q), .flag_q(flag_q),
  .irq_ovf(irq_ovf), .irq_edge(irq_edge), .tmr_clk(tmr_clk), .presc_clk(presc_clk)
);

// File: tb/sim_pacc_clksel.sv
`timescale 1ns/1ps
module sim_pacc_clksel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        pulse_in = 1'b0;
  logic        presc_clk = 1'b0;
  logic        tmr_clk;
  logic        irq_ovf;
  logic        irq_edge;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pacc_clksel u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pulse_in(pulse_in),
    .presc_clk(presc_clk), .tmr_clk(tmr_clk), .irq_ovf(irq_ovf), .irq_edge(irq_edge)
  );

  // behavioural reference
  bit h0, h1, h2;
  int m_cnt, m_ctrl;
  bit m_fo, m_fe;

  function automatic bit m_step();
    return h1 && !h2 && m_ctrl[0] && !(reg_wr && reg_addr == 2'd2);
  endfunction

  function automatic bit m_tmr();
    bit st;
    st = m_step();
    if (!m_ctrl[0]) return presc_clk;
    case ((m_ctrl >> 3) & 3)
      0: return presc_clk;
      1: return st;
      2: return st && ((m_cnt & 255) == 255);
      default: return st && (m_cnt == 65535);
    endcase
  endfunction

  function automatic int m_read(int a);
    case (a)
      0: return m_ctrl & 31;
      1: return {m_fo, m_fe};
      2: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0 = 0; h1 = 0; h2 = 0; m_cnt = 0; m_ctrl = 0; m_fo = 0; m_fe = 0;
    end else begin
      bit st, wp;
      st = m_step();
      wp = st && (m_cnt == 65535);
      if (reg_wr && reg_addr == 2'd1) begin
        if (reg_wdata[1]) m_fo = 0;
        if (reg_wdata[0]) m_fe = 0;
      end
      if (wp) m_fo = 1;
      if (st) m_fe = 1;
      if (reg_wr && reg_addr == 2'd2) m_cnt = int'(reg_wdata);
      else if (st) m_cnt = (m_cnt + 1) & 65535;
      if (reg_wr && reg_addr == 2'd0) m_ctrl = int'(reg_wdata) & 31;
      h2 = h1; h1 = h0; h0 = pulse_in;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      case (reg_addr)
        2'd0: check("R11 ctrl readback", int'(reg_rdata), m_read(0));
        2'd1: check("R5 flag readback", int'(reg_rdata), m_read(1));
        2'd2: check("R1 R2 count readback", int'(reg_rdata), m_read(2));
        default: check("R11 unused address", int'(reg_rdata), 0);
      endcase
      check("R7 irq_ovf", int'(irq_ovf), int'(m_fo && m_ctrl[1]));
      check("R7 irq_edge", int'(irq_edge), int'(m_fe && m_ctrl[2]));
      check("R8 R9 R10 tmr_clk", int'(tmr_clk), int'(m_tmr()));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic pulse(int hi, int lo);
    pulse_in = 1'b1;
    repeat (hi) tick();
    pulse_in = 1'b0;
    repeat (lo) tick();
  endtask

  task automatic read_at_neg(logic [1:0] a, output int v);
    reg_addr = a;
    @(negedge clk);
    v = int'(reg_rdata);
    tick();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R11: reset state
    read_at_neg(2'd0, v); check("R11 ctrl after reset", v, 0);
    read_at_neg(2'd1, v); check("R11 flags after reset", v, 0);
    read_at_neg(2'd2, v); check("R11 count after reset", v, 0);

    // R1: disabled accumulator ignores pulses
    reg_addr = 2'd2;
    repeat (4) pulse(2, 2);
    read_at_neg(2'd2, v); check("R1 count held while disabled", v, 0);

    // R1 R4: enable, pulse clock selected, irqs enabled
    wr(2'd0, 16'h000F);
    reg_addr = 2'd2;
    repeat (5) pulse(3, 3);
    repeat (3) tick();
    read_at_neg(2'd2, v); check("R1 five edges counted", v, 5);
    read_at_neg(2'd1, v); check("R4 edge flag set", v, 1);
    // R5: writing zeros leaves flags unchanged
    wr(2'd1, 16'h0000);
    read_at_neg(2'd1, v); check("R5 write 0 no effect", v, 1);
    wr(2'd1, 16'hFFFD);
    read_at_neg(2'd1, v); check("R5 write 1 clears edge flag", v, 0);

    // R1: fast single-cycle pulses
    reg_addr = 2'd2;
    repeat (6) pulse(1, 1);
    repeat (3) tick();
    read_at_neg(2'd2, v); check("R1 fast pulses counted", v, 11);

    // R3 R8: wrap with full divide selected
    wr(2'd0, 16'h001F);
    wr(2'd2, 16'hFFFD);
    wr(2'd1, 16'h0003);
    reg_addr = 2'd1;
    repeat (4) pulse(2, 2);
    repeat (3) tick();
    read_at_neg(2'd2, v); check("R3 count after wrap", v, 1);
    read_at_neg(2'd1, v); check("R3 overflow flag set", v, 3);
    wr(2'd1, 16'h0002);
    read_at_neg(2'd1, v); check("R5 clear overflow only", v, 1);

    // R8: low-byte carry divide
    wr(2'd0, 16'h0017);
    wr(2'd2, 16'h01FC);
    reg_addr = 2'd2;
    repeat (6) pulse(2, 3);
    repeat (3) tick();
    read_at_neg(2'd2, v); check("R8 count across byte carry", v, 16'h0202);

    // R6: set and clear in the same cycle
    wr(2'd0, 16'h000F);
    wr(2'd1, 16'h0003);
    pulse_in = 1'b1;
    tick(); tick();
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0001;
    tick();
    reg_wr = 1'b0; pulse_in = 1'b0;
    @(negedge clk); v = int'(reg_rdata);
    check("R6 set wins over clear", v, 1);
    tick();

    // R2: count write beats a simultaneous edge
    pulse_in = 1'b1;
    tick(); tick();
    wr(2'd2, 16'h1234);
    pulse_in = 1'b0;
    repeat (2) tick();
    read_at_neg(2'd2, v); check("R2 write wins over edge", v, 16'h1234);

    // R9: disabled, every select passes the prescaler
    for (int s = 0; s < 4; s++) begin
      wr(2'd0, 16'((s << 3) | 6));
      for (int i = 0; i < 8; i++) begin
        presc_clk = 1'(i & 1); pulse_in = 1'(i >> 1);
        tick();
      end
    end
    presc_clk = 1'b0;

    // R10: select sweep while enabled, random stimulus
    for (int i = 0; i < 1500; i++) begin
      presc_clk = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 2) == 0) pulse_in = ~pulse_in;
      case ($urandom_range(0, 15))
        0: begin reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 16'($urandom_range(0, 31) | 1); end
        1: begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 16'($urandom_range(0, 3)); end
        2: begin reg_wr = 1'b1; reg_addr = 2'd2;
                 reg_wdata = ($urandom_range(0, 1) != 0) ? 16'hFFFE : 16'h00FE; end
        default: begin reg_wr = 1'b0; reg_addr = 2'($urandom_range(0, 3)); end
      endcase
      tick();
    end
    reg_wr = 1'b0;
    repeat (4) tick();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule